// File: doc/BRIEF.md
# Pipelined Converter Output Interface

This block is the digital back end of a pipelined sampling converter. A stand-in core hands it one raw 14-bit signed sample and an out-of-range flag. The block divides its input clock by two to form the sample phase, so the clock's duty cycle does not matter. It delays every sample by a fixed number of sample periods and presents the result on a parallel two's-complement bus. The out-of-range bit travels with each word, and a data-valid strobe marks each word.

Every second input clock edge is a sample edge. At that edge the block takes the input, applies saturation and shifts the delay line. The output word and its range bit change only at sample edges. The valid strobe rises at the edge in between and falls at the next sample edge, so it marks each word for one input-clock period while the word is stable. An output-enable input floats the data bus and the range bit. The strobe stays driven at all times.

Top module: `conv_out_if`

## Requirements
- R1: After reset, the first clock edge is a sample edge, and sample edges then alternate with non-sample edges; once the pipeline is full, the valid strobe is high for exactly one input-clock period in every two.
- R2: The word and range bit taken at sample edge n appear on the outputs right after sample edge n+4, with sample edges counted from 0 after reset.
- R3: With the flag clear, the output word equals the sample taken, bit for bit, as a 14-bit two's-complement value with bit 13 the sign bit; this includes the extremes 0x1FFF and 0x2000.
- R4: The range output bit equals the flag taken with the same sample.
- R5: With the flag set, the word saturates according to bit 13 of the raw sample: bit 13 = 0 gives 0x1FFF, and bit 13 = 1 gives 0x2000.
- R6: While the output-enable input is low, all 14 data bits and the range bit are high impedance. While it is high, they are driven with the current word.
- R7: The valid strobe behaves the same whatever the output-enable input does.
- R8: After reset, the strobe stays low until the word from the first sample is on the outputs. The first high strobe starts at clock edge 10, with edges counted from 1 after reset is released.
- R9: The output word and range bit do not change while the strobe is high.
- R10: During reset, and right after it, the strobe is low, the range bit is 0 and the enabled bus reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock, twice the sample rate |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleIn | input | 14 | Raw two's-complement sample from the core |
| sampleOor | input | 1 | Out-of-range flag for sampleIn |
| outEn | input | 1 | Output enable for dataBus and oorBit |
| dataBus | output | 14 | Delayed output word, tri-stated when outEn is low |
| oorBit | output | 1 | Range bit of the word on dataBus, tri-stated when outEn is low |
| dataValid | output | 1 | One-clock strobe marking each output word |

## Verification
Two functions can fall in the same cycle: the output-enable gating and the strobe or word update. The enable can also change on the very clock in which a word is replaced or the strobe rises. The bench toggles the enable at random on every clock and keeps it busy across the first strobe after each reset. It then checks that the strobe and the delayed word sequence match the reference model with no gap or shift, and that the bus reads high impedance exactly in the cycles where the enable is low. A word that is saturated in the same sample period in which an unsaturated extreme code is passed through is also checked against the model, so that the flag and the sign bit of the code are judged separately.

// File: rtl/conv_out_pkg.sv
package conv_out_pkg;
  // Strobes passed from the control module to the datapath.
  typedef struct packed {
    logic sampleTick;  // this edge is a sample edge
  } ctrl_strobe_t;

  function automatic logic [13:0] satCode(input logic [13:0] raw, input logic oor);
    if (!oor) return raw;
    return raw[13] ? 14'h2000 : 14'h1FFF;
  endfunction
endpackage

// File: rtl/conv_out_ctrl.sv
module conv_out_ctrl
  import conv_out_pkg::*;
#(
  parameter int LATENCY = 4
) (
  input  logic         clk,
  input  logic         rstN,
  output ctrl_strobe_t ctl,
  output logic         dataValid
);
  localparam int FILL_LIM = LATENCY + 1;
  localparam int CNT_W    = $clog2(FILL_LIM + 1);

  logic             phase;
  logic [CNT_W-1:0] fillCnt;
  logic             filled;

  assign ctl.sampleTick = ~phase;
  assign filled         = (fillCnt == CNT_W'(FILL_LIM));

  // Divide-by-two sample phase.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= 1'b0;
    else       phase <= ~phase;
  end

  // Counts sample edges until the first word reaches the output.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         fillCnt <= '0;
    else if (ctl.sampleTick && !filled) fillCnt <= fillCnt + 1'b1;
  end

  // Strobe rises on a non-sample edge and falls at the next sample edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataValid <= 1'b0;
    else       dataValid <= !ctl.sampleTick && filled;
  end
endmodule

// File: rtl/conv_out_path.sv
module conv_out_path
  import conv_out_pkg::*;
#(
  parameter int WIDTH   = 14,
  parameter int LATENCY = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     ctl,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             sampleOor,
  output logic [WIDTH-1:0] wordQ,
  output logic             oorQ
);
  localparam int ENTRY_W = WIDTH + 1;
  localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH-1:0]   satWord;
  logic [ENTRY_W-1:0] stage [LATENCY];

  always_comb begin
    if (!sampleOor)           satWord = sampleIn;
    else if (sampleIn[WIDTH-1]) satWord = NEG_MIN;
    else                      satWord = POS_MAX;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stage[0] <= '0;
    else if (ctl.sampleTick) stage[0] <= {sampleOor, satWord};
  end

  for (genvar i = 1; i < LATENCY; i++) begin : g_delay
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               stage[i] <= '0;
      else if (ctl.sampleTick) stage[i] <= stage[i-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ <= '0;
      oorQ  <= 1'b0;
    end else if (ctl.sampleTick) begin
      {oorQ, wordQ} <= stage[LATENCY-1];
    end
  end
endmodule

// File: rtl/conv_out_if.sv
module conv_out_if
  import conv_out_pkg::*;
#(
  parameter int WIDTH   = 14,
  parameter int LATENCY = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] sampleIn,
  input  logic             sampleOor,
  input  logic             outEn,
  output logic [WIDTH-1:0] dataBus,
  output logic             oorBit,
  output logic             dataValid
);
  ctrl_strobe_t     ctl;
  logic [WIDTH-1:0] wordQ;
  logic             oorQ;

  conv_out_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataValid(dataValid)
  );

  conv_out_path #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .sampleIn(sampleIn),
    .sampleOor(sampleOor), .wordQ(wordQ), .oorQ(oorQ)
  );

  assign dataBus = outEn ? wordQ : {WIDTH{1'bz}};
  assign oorBit  = outEn ? oorQ  : 1'bz;
endmodule

// File: rtl/conv_out_chk.sv
module conv_out_chk #(
  parameter int WIDTH   = 14,
  parameter int LATENCY = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             dataValid,
  input logic [WIDTH-1:0] wordQ,
  input logic             oorQ
);
  localparam int FIRST_EDGE = 2 * LATENCY + 2;
  localparam logic [WIDTH-1:0] POS_MAX = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] NEG_MIN = {1'b1, {(WIDTH-1){1'b0}}};

  int unsigned edgeCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    edgeCnt <= 0;
    else if (edgeCnt < FIRST_EDGE) edgeCnt <= edgeCnt + 1;
  end

  AST_STROBE_ALTERNATES: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |=> !dataValid) else $error("strobe high two clocks"); // R1

  AST_NO_EARLY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> edgeCnt >= FIRST_EDGE) else $error("strobe before fill"); // R8

  AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> ($stable(wordQ) && $stable(oorQ))) else $error("word moved under strobe"); // R9

  AST_SAT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    oorQ |-> (wordQ == POS_MAX || wordQ == NEG_MIN)) else $error("flagged word not saturated"); // R5
endmodule

bind conv_out_if conv_out_chk #(.WIDTH(WIDTH), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rstN(rstN), .dataValid(dataValid), .wordQ(wordQ), .oorQ(oorQ)
);

// File: tb/sim_conv_out_if.sv
`timescale 1ns/1ps
module sim_conv_out_if;
  localparam int W = 14;
  localparam int L = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] sampleIn = '0;
  logic         sampleOor = 1'b0;
  logic         outEn = 1'b1;
  wire  [W-1:0] dataBus;
  wire          oorBit;
  wire          dataValid;

  int nChk = 0;
  int nFail = 0;

  conv_out_if u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .sampleOor(sampleOor),
    .outEn(outEn), .dataBus(dataBus), .oorBit(oorBit), .dataValid(dataValid)
  );

  always #10 clk = ~clk;

  // Behavioural reference model.
  logic [W:0]  hist[$];
  int          refPh, refSamples, edgeNo, firstValidEdge;
  logic [W-1:0] expWord;
  logic        expOor, expValid;

  function automatic logic [W-1:0] sat(input logic [W-1:0] r, input logic f);
    if (!f) return r;
    return r[W-1] ? 14'h2000 : 14'h1FFF;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hist.delete(); refPh = 0; refSamples = 0; edgeNo = 0;
      expWord = '0; expOor = 1'b0; expValid = 1'b0;
    end else begin
      edgeNo++;
      if (refPh == 0) begin
        hist.push_back({sampleOor, sat(sampleIn, sampleOor)});
        if (hist.size() == L + 1) {expOor, expWord} = hist.pop_front();
        refSamples++;
        expValid = 1'b0;
        refPh = 1;
      end else begin
        expValid = (refSamples >= L + 1);
        refPh = 0;
      end
    end
  end

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  logic [W-1:0] prevBus;
  logic         prevOe, prevValid;

  // Compare all outputs, just before the next input change.
  task automatic compare_all();
    logic [W-1:0] eBus;
    logic         eOor;
    eBus = outEn ? expWord : {W{1'bz}};
    eOor = outEn ? expOor : 1'bz;
    check("R2 R3 R5 R6 data", {1'b0, dataBus}, {1'b0, eBus});
    check("R4 R6 range bit", {{W{1'b0}}, oorBit}, {{W{1'b0}}, eOor});
    check("R1 R7 R8 strobe", {{W{1'b0}}, dataValid}, {{W{1'b0}}, expValid});
    if (dataValid && !prevValid && outEn && prevOe)
      check("R9 stable under strobe", {1'b0, dataBus}, {1'b0, prevBus});
    if (dataValid && !prevValid && firstValidEdge < 0) begin
      firstValidEdge = edgeNo;
      check("R8 first strobe edge", (W+1)'(firstValidEdge), (W+1)'(2 * L + 2));
    end
    prevBus = dataBus; prevOe = outEn; prevValid = dataValid;
  endtask

  task automatic run(input int n, input bit randOe, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare_all();
      if (randOe) outEn = ($urandom_range(0, 3) != 0);
      case (mode)
        0: begin sampleIn = W'($urandom); sampleOor = ($urandom_range(0, 7) == 0); end
        1: begin sampleIn = (i % 4 < 2) ? 14'h1FFF : 14'h2000; sampleOor = (i % 8 >= 4); end
        default: begin sampleIn = W'(i * 37); sampleOor = 1'b0; end
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    compare_all();
    rstN = 1'b0;
    #1;
    // R10: reset state while held
    check("R10 reset strobe", {{W{1'b0}}, dataValid}, '0);
    outEn = 1'b1; #1;
    check("R10 reset bus", {1'b0, dataBus}, '0);
    check("R10 reset range", {{W{1'b0}}, oorBit}, '0);
    repeat (2) @(negedge clk);
    firstValidEdge = -1; prevValid = 1'b0;
    rstN = 1'b1;
  endtask

  initial begin
    firstValidEdge = -1; prevValid = 1'b0; prevOe = 1'b0; prevBus = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R10 reset strobe", {{W{1'b0}}, dataValid}, '0);
    check("R10 reset bus", {1'b0, dataBus}, '0);
    rstN = 1'b1;
    run(200, 1'b0, 2);      // ramp, bus enabled
    run(400, 1'b0, 1);      // extremes and saturation
    run(800, 1'b1, 0);      // random data, random enable
    do_reset();
    run(600, 1'b1, 0);      // enable busy across the first strobe
    do_reset();
    outEn = 1'b0;
    run(60, 1'b0, 2);       // bus floated throughout fill
    run(300, 1'b1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #2000000;
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule